// File: doc/BRIEF.md
# Host Command Decoder with Telegram Buffer

This block sits behind a byte-wide serial receiver that listens to a host controller. Each byte the host sends is either a control byte or the operand that a previous control byte announced. The decoder sorts control bytes into housekeeping commands, acknowledge settings, polling-state commands and frame-building commands. Frame-building commands carry the position of the following byte inside the outgoing bus telegram. The block writes those bytes into a 64-entry buffer and checks that the positions arrive in order. When the closing command arrives, it compares the announced length and the checksum, and only then hands the telegram to the bus transmitter.

Problems are reported back to the host through a status byte. That byte carries four sticky error flags and a live over-temperature bit, and its three low bits are always ones. A status byte is sent when the host asks for one and whenever an error is recorded. The flags carried by a byte are cleared once the host-side transmitter accepts that byte. The bus transmitter reads the released telegram through a random-access port and returns the buffer with a one-cycle done pulse.

Top module: `hostcmd_frame_asm`

## Requirements
- R1: Byte 0x02 produces one status byte on tx_byte. Its layout is bit7 slave collision, bit6 receive error, bit5 transmit error, bit4 protocol error, bit3 temperature warning, and bits 2..0 always 111. With no error recorded, the byte is 0x07.
- R2: tx_byte holds steady while tx_valid is high and tx_ready is low. When a status byte is accepted, only the flags it carried are cleared. A flag set after the byte was loaded stays set and causes a further status byte.
- R3: Byte 0x80 stores the next byte at buffer index 0. Byte 0x80|i, for i from 1 to 62, stores the next byte at index i. A released telegram reads back byte for byte through frm_rd_addr and frm_rd_data.
- R4: Byte 0x40|n, with n from 7 to 63, is followed by a checksum. The telegram is released when n equals the number of bytes stored and the XOR of all stored bytes and the checksum is 0xFF. On release, frm_valid goes high with frm_len = n and stays high until frm_done.
- R5: A checksum that fails the rule of R4 sets the receive-error flag, causes a status byte, and releases nothing.
- R6: Any of the following sets the protocol-error flag, causes a status byte, drops the telegram and discards the byte that follows: a data index other than the last stored index plus one, or a data or end command with no telegram open.
- R7: An end command whose count differs from the number of stored bytes sets the protocol-error flag, causes a status byte, releases nothing and discards the checksum byte.
- R8: Every control byte outside the defined set sets the protocol-error flag and causes a status byte. Examples are 0x00, 0x03, 0x20, 0x46 and 0xBF.
- R9: A byte received with rx_perr high is ignored as a command. It sets the receive-error flag, causes a status byte, and aborts any telegram or operand sequence in progress.
- R10: Byte 0x05 sets mon_mode. Only byte 0x01 clears it. Byte 0x01 also clears the flags, any pending status byte, any open telegram and any released telegram.
- R11: Bytes 0x10 to 0x17 pulse ack_valid for one cycle. ack_flags then equals bits 2..0 of the byte: bit 2 is not-acknowledge, bit 1 is busy, bit 0 is addressed. No status byte follows.
- R12: Bytes 0xE0 to 0xEF take the next three bytes as poll address high, poll address low and poll state. After the third byte, poll_valid pulses with poll_slot equal to bits 3..0 of the command.
- R13: While a released telegram waits for frm_done, a start, data or end command sets the protocol-error flag and its operand byte is discarded. The held telegram and frm_len do not change.
- R14: A pulse on sc_evt or te_evt sets the slave-collision or transmit-error flag and causes a status byte. temp_warn is copied into bit 3 at the moment a status byte is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_byte | input | 8 | Byte received from the host |
| rx_valid | input | 1 | rx_byte is present this cycle |
| rx_perr | input | 1 | Parity failure on rx_byte |
| tx_byte | output | 8 | Status byte towards the host transmitter |
| tx_valid | output | 1 | tx_byte is offered |
| tx_ready | input | 1 | Host transmitter takes tx_byte |
| frm_valid | output | 1 | A checked telegram is ready for the bus |
| frm_len | output | 6 | Byte count of the released telegram |
| frm_rd_addr | input | 6 | Buffer read index |
| frm_rd_data | output | 8 | Buffer byte at frm_rd_addr |
| frm_done | input | 1 | Bus side has finished with the telegram |
| mon_mode | output | 1 | Bus-monitor mode is active |
| ack_valid | output | 1 | One-cycle acknowledge-setting strobe |
| ack_flags | output | 3 | {not-acknowledge, busy, addressed} |
| poll_valid | output | 1 | One-cycle polling-state strobe |
| poll_slot | output | 4 | Polling slot number |
| poll_addr | output | 16 | Polling address, high byte first received |
| poll_state | output | 8 | Polling state byte |
| sc_evt | input | 1 | Slave collision seen on the bus |
| te_evt | input | 1 | Transmit error seen on the bus |
| temp_warn | input | 1 | Over-temperature level |

## Verification
The bench targets the telegram edge cases: the longest telegram of 63 bytes, the shortest legal end count of 7, an index that skips ahead, an end count one too high, and a parity failure part-way through a telegram. In several of these cases the byte that must be discarded is chosen to be 0x02 or 0x00. A decoder that failed to skip it would emit a second status byte, which the bench detects by watching for silence. The bench also raises a transmit error while a status byte is held. A design that cleared every flag on acceptance would lose that error and never send the follow-up 0x27. A command sent while a telegram is held must leave the buffer contents and frm_len untouched.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 6;
  localparam int MIN_END = 7;
  localparam int MAX_IDX = 62;

  typedef enum logic [3:0] {
    K_RESET, K_STATE, K_MON, K_ACK, K_START, K_CONT, K_END, K_POLL, K_BAD
  } cmd_kind_e;

  typedef enum logic [2:0] {
    D_CMD, D_CTRL, D_DATA, D_SUM, D_PHI, D_PLO, D_PST, D_SKIP
  } dec_st_e;

  // sort a host control byte into its command class
  function automatic cmd_kind_e classify(input logic [7:0] b);
    cmd_kind_e k;
    if (b == 8'h01)                                       k = K_RESET;
    else if (b == 8'h02)                                  k = K_STATE;
    else if (b == 8'h05)                                  k = K_MON;
    else if (b[7:3] == 5'b00010)                          k = K_ACK;
    else if (b == 8'h80)                                  k = K_START;
    else if (b[7:6] == 2'b10 && int'(b[5:0]) <= MAX_IDX)  k = K_CONT;
    else if (b[7:6] == 2'b01 && int'(b[5:0]) >= MIN_END)  k = K_END;
    else if (b[7:4] == 4'hE)                              k = K_POLL;
    else                                                  k = K_BAD;
    return k;
  endfunction

  // flags are {slave collision, receive, transmit, protocol}
  function automatic logic [7:0] pack_status(input logic [3:0] f, input logic tw);
    return {f, tw, 3'b111};
  endfunction

  function automatic logic csum_ok(input logic [7:0] acc, input logic [7:0] chk);
    return (acc ^ chk) == 8'hFF;
  endfunction
endpackage

// File: rtl/hcf_frame_buf.sv
module hcf_frame_buf #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/hcf_cmd_dec.sv
module hcf_cmd_dec
  import hcf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rx_byte,
  input  logic          rx_valid,
  input  logic          rx_perr,
  input  logic          frame_busy,
  output logic          buf_we,
  output logic [AW-1:0] buf_waddr,
  output logic [7:0]    buf_wdata,
  output logic          ev_pe,
  output logic          ev_re,
  output logic          ev_sreq,
  output logic          ev_rst,
  output logic          rel,
  output logic [AW-1:0] rel_len,
  output logic          mon_mode,
  output logic          ack_valid,
  output logic [2:0]    ack_flags,
  output logic          poll_valid,
  output logic [3:0]    poll_slot,
  output logic [15:0]   poll_addr,
  output logic [7:0]    poll_state
);
  dec_st_e       st;
  logic          open_q;
  logic [AW-1:0] nxt_idx, cur_idx;
  logic [7:0]    acc;
  cmd_kind_e     kind;
  logic [AW-1:0] idx_f;
  logic          seq_bad;

  assign kind      = classify(rx_byte);
  assign idx_f     = rx_byte[AW-1:0];
  assign seq_bad   = frame_busy || !open_q || (idx_f != nxt_idx);
  assign buf_wdata = rx_byte;
  assign rel_len   = nxt_idx;

  always_comb begin
    ev_pe = 1'b0; ev_re = 1'b0; ev_sreq = 1'b0; ev_rst = 1'b0;
    buf_we = 1'b0; buf_waddr = cur_idx; rel = 1'b0;
    if (rx_valid) begin
      if (rx_perr) ev_re = 1'b1;
      else begin
        case (st)
          D_CMD: begin
            case (kind)
              K_RESET: ev_rst  = 1'b1;
              K_STATE: ev_sreq = 1'b1;
              K_BAD:   ev_pe   = 1'b1;
              K_START: ev_pe   = frame_busy;
              K_CONT:  ev_pe   = seq_bad;
              K_END:   ev_pe   = seq_bad;
              default: ;
            endcase
          end
          D_CTRL: begin buf_we = 1'b1; buf_waddr = '0; end
          D_DATA: buf_we = 1'b1;
          D_SUM: begin
            if (csum_ok(acc, rx_byte)) rel = 1'b1;
            else                       ev_re = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= D_CMD; open_q <= 1'b0; nxt_idx <= '0; cur_idx <= '0; acc <= '0;
      mon_mode <= 1'b0; ack_valid <= 1'b0; ack_flags <= '0;
      poll_valid <= 1'b0; poll_slot <= '0; poll_addr <= '0; poll_state <= '0;
    end else begin
      ack_valid  <= 1'b0;
      poll_valid <= 1'b0;
      if (rx_valid) begin
        if (rx_perr) begin
          st <= D_CMD; open_q <= 1'b0;
        end else begin
          case (st)
            D_CMD: begin
              case (kind)
                K_RESET: begin mon_mode <= 1'b0; open_q <= 1'b0; end
                K_MON:   mon_mode <= 1'b1;
                K_ACK:   begin ack_valid <= 1'b1; ack_flags <= rx_byte[2:0]; end
                K_START: begin
                  open_q <= 1'b0;
                  st <= frame_busy ? D_SKIP : D_CTRL;
                end
                K_CONT: begin
                  if (seq_bad) begin st <= D_SKIP; open_q <= 1'b0; end
                  else begin st <= D_DATA; cur_idx <= idx_f; end
                end
                K_END: begin
                  if (seq_bad) begin st <= D_SKIP; open_q <= 1'b0; end
                  else st <= D_SUM;
                end
                K_POLL: begin poll_slot <= rx_byte[3:0]; st <= D_PHI; end
                default: ;
              endcase
            end
            D_CTRL: begin
              acc <= rx_byte; nxt_idx <= AW'(1); open_q <= 1'b1; st <= D_CMD;
            end
            D_DATA: begin
              acc <= acc ^ rx_byte; nxt_idx <= nxt_idx + AW'(1); st <= D_CMD;
            end
            D_SUM:  begin open_q <= 1'b0; st <= D_CMD; end
            D_PHI:  begin poll_addr[15:8] <= rx_byte; st <= D_PLO; end
            D_PLO:  begin poll_addr[7:0]  <= rx_byte; st <= D_PST; end
            D_PST:  begin poll_state <= rx_byte; poll_valid <= 1'b1; st <= D_CMD; end
            default: st <= D_CMD;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hcf_status.sv
module hcf_status
  import hcf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_pe,
  input  logic       ev_re,
  input  logic       ev_sc,
  input  logic       ev_te,
  input  logic       ev_sreq,
  input  logic       ev_rst,
  input  logic       tw,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       pend
);
  logic [3:0] flags, rep, new_f, content;
  logic       trig, load, accept;

  assign new_f   = {ev_sc, ev_re, ev_te, ev_pe};
  assign trig    = (|new_f) | ev_sreq;
  assign load    = pend && !tx_valid;
  assign accept  = tx_valid && tx_ready;
  assign content = flags | new_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0; rep <= '0; pend <= 1'b0; tx_valid <= 1'b0; tx_byte <= '0;
    end else if (ev_rst) begin
      flags <= '0; pend <= 1'b0;
      if (accept) tx_valid <= 1'b0;
    end else begin
      flags <= (accept ? (flags & ~rep) : flags) | new_f;
      pend  <= load ? 1'b0 : (pend | trig);
      if (load) begin
        tx_valid <= 1'b1;
        tx_byte  <= pack_status(content, tw);
        rep      <= content;
      end else if (accept) begin
        tx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hostcmd_frame_asm.sv
module hostcmd_frame_asm
  import hcf_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  localparam int AW = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rx_byte,
  input  logic          rx_valid,
  input  logic          rx_perr,
  output logic [7:0]    tx_byte,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          frm_valid,
  output logic [AW-1:0] frm_len,
  input  logic [AW-1:0] frm_rd_addr,
  output logic [7:0]    frm_rd_data,
  input  logic          frm_done,
  output logic          mon_mode,
  output logic          ack_valid,
  output logic [2:0]    ack_flags,
  output logic          poll_valid,
  output logic [3:0]    poll_slot,
  output logic [15:0]   poll_addr,
  output logic [7:0]    poll_state,
  input  logic          sc_evt,
  input  logic          te_evt,
  input  logic          temp_warn
);
  logic          buf_we;
  logic [AW-1:0] buf_waddr;
  logic [7:0]    buf_wdata;
  logic          ev_pe, ev_re, ev_sreq, ev_rst, rel_frame, stat_pend;
  logic [AW-1:0] rel_len;

  hcf_cmd_dec #(.AW(AW)) u_dec (
    .clk, .rst_n, .rx_byte, .rx_valid, .rx_perr,
    .frame_busy(frm_valid),
    .buf_we, .buf_waddr, .buf_wdata,
    .ev_pe, .ev_re, .ev_sreq, .ev_rst,
    .rel(rel_frame), .rel_len,
    .mon_mode, .ack_valid, .ack_flags,
    .poll_valid, .poll_slot, .poll_addr, .poll_state
  );

  hcf_frame_buf #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_buf (
    .clk, .wr_en(buf_we), .wr_addr(buf_waddr), .wr_data(buf_wdata),
    .rd_addr(frm_rd_addr), .rd_data(frm_rd_data)
  );

  hcf_status u_stat (
    .clk, .rst_n, .ev_pe, .ev_re, .ev_sc(sc_evt), .ev_te(te_evt),
    .ev_sreq, .ev_rst, .tw(temp_warn), .tx_ready,
    .tx_valid, .tx_byte, .pend(stat_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_valid <= 1'b0; frm_len <= '0;
    end else if (ev_rst) begin
      frm_valid <= 1'b0;
    end else if (rel_frame) begin
      frm_valid <= 1'b1; frm_len <= rel_len;
    end else if (frm_done) begin
      frm_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hcf_chk.sv
module hcf_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_byte,
  input logic          frm_valid,
  input logic          frm_done,
  input logic [AW-1:0] frm_len,
  input logic          mon_mode,
  input logic          ev_rst,
  input logic          ev_pe,
  input logic          rel_frame,
  input logic          stat_pend
);
  p_low_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_byte[2:0] == 3'b111);

  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_frame && !ev_rst |=> frm_valid);

  p_frm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !frm_done && !ev_rst |=> frm_valid && $stable(frm_len));

  p_len_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> frm_len >= AW'(7));

  p_pe_reported_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pe && !ev_rst |=> stat_pend || tx_valid);

  p_mon_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mon_mode && !ev_rst |=> mon_mode);
endmodule

bind hostcmd_frame_asm hcf_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_byte(tx_byte), .frm_valid(frm_valid), .frm_done(frm_done),
  .frm_len(frm_len), .mon_mode(mon_mode), .ev_rst(ev_rst), .ev_pe(ev_pe),
  .rel_frame(rel_frame), .stat_pend(stat_pend)
);

// File: tb/sim_hostcmd_frame_asm.sv
module sim_hostcmd_frame_asm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0, rx_perr = 1'b0, tx_ready = 1'b0;
  logic        frm_done = 1'b0, sc_evt = 1'b0, te_evt = 1'b0, temp_warn = 1'b0;
  logic [5:0]  frm_rd_addr = '0;
  logic [7:0]  tx_byte, frm_rd_data, poll_state;
  logic        tx_valid, frm_valid, mon_mode, ack_valid, poll_valid;
  logic [5:0]  frm_len;
  logic [2:0]  ack_flags;
  logic [3:0]  poll_slot;
  logic [15:0] poll_addr;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_mem [64];

  always #10 clk = ~clk;

  hostcmd_frame_asm u0 (.*);

  // {status expected, command byte, expected status byte}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'h02, 8'h07}, {1'b1, 8'h00, 8'h17}, {1'b1, 8'h03, 8'h17},
    {1'b1, 8'hBF, 8'h17}, {1'b1, 8'h46, 8'h17}, {1'b1, 8'h20, 8'h17},
    {1'b1, 8'h02, 8'h07}, {1'b0, 8'h13, 8'h00}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit perr = 1'b0);
    @(negedge clk); rx_byte = b; rx_perr = perr; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0; rx_perr = 1'b0;
  endtask

  task automatic take_status(input logic [7:0] exp, input string tag, input bit accept = 1'b1);
    for (int k = 0; k < 12 && !tx_valid; k++) @(negedge clk);
    check(tx_valid === 1'b1 && tx_byte === exp, tag, tx_valid ? int'(tx_byte) : 'h100, exp);
    if (accept) begin
      tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    end
  endtask

  task automatic expect_quiet(input string tag);
    repeat (6) @(negedge clk);
    check(tx_valid === 1'b0, tag, tx_valid, 0);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  // sends indices 0..cnt-1, then end command with end_n and a checksum
  task automatic send_frame(input int cnt, input int end_n, input bit good, input logic [7:0] seed);
    logic [7:0] x = '0;
    for (int i = 0; i < cnt; i++) begin
      exp_mem[i] = seed + 8'(i * 29);
      x ^= exp_mem[i];
      send(i == 0 ? 8'h80 : (8'h80 | 8'(i)));
      send(exp_mem[i]);
    end
    send(8'h40 | 8'(end_n));
    send(good ? ~x : (~x ^ 8'h01));
  endtask

  task automatic readback(input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); frm_rd_addr = 6'(i); #1;
      check(frm_rd_data === exp_mem[i], tag, frm_rd_data, exp_mem[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_valid === 0 && frm_valid === 0 && mon_mode === 0 && ack_valid === 0 && poll_valid === 0,
          "reset state", {tx_valid, frm_valid, mon_mode, ack_valid, poll_valid}, 0);

    // table walk: R1 state request, R8 illegal bytes, R11 acknowledge
    foreach (VEC[v]) begin
      send(VEC[v][15:8]);
      if (VEC[v][16]) begin
        take_status(VEC[v][7:0], VEC[v][7:0] == 8'h07 ? "R1 state response" : "R8 illegal byte");
      end else begin
        check(ack_valid === 1'b1 && ack_flags === VEC[v][10:8], "R11 ack strobe", ack_flags, VEC[v][10:8]);
        expect_quiet("R11 no status after ack");
      end
    end

    // R3 / R4 good frame of 9 bytes
    send_frame(9, 9, 1'b1, 8'h3C);
    check(frm_valid === 1'b1 && frm_len === 6'd9, "R4 release len 9", frm_len, 9);
    readback(9, "R3 readback");
    // R13 commands while held
    send(8'h80); send(8'h02);
    take_status(8'h17, "R13 start while held");
    expect_quiet("R13 operand skipped");
    check(frm_valid === 1'b1 && frm_len === 6'd9, "R13 held frame kept", frm_len, 9);
    readback(2, "R13 contents kept");
    pulse(frm_done);
    check(frm_valid === 1'b0, "R4 done drops valid", frm_valid, 0);

    // R4 longest telegram
    send_frame(63, 63, 1'b1, 8'hA5);
    check(frm_valid === 1'b1 && frm_len === 6'd63, "R4 release len 63", frm_len, 63);
    readback(63, "R3 readback long");
    pulse(frm_done);

    // R5 bad checksum, shortest legal count
    send_frame(7, 7, 1'b0, 8'h11);
    take_status(8'h47, "R5 bad checksum");
    check(frm_valid === 1'b0, "R5 nothing released", frm_valid, 0);

    // R6 skipped index, operand 0x02 must be dropped
    send(8'h80); send(8'h11); send(8'h82); send(8'h02);
    take_status(8'h17, "R6 index skip");
    expect_quiet("R6 operand dropped");
    send(8'h47); send(8'h00);
    take_status(8'h17, "R6 end with no open frame");
    expect_quiet("R6 checksum dropped");

    // R7 count mismatch
    send_frame(8, 9, 1'b1, 8'h50);
    take_status(8'h17, "R7 count mismatch");
    expect_quiet("R7 checksum dropped");
    check(frm_valid === 1'b0, "R7 nothing released", frm_valid, 0);

    // R9 parity
    send(8'h02, 1'b1);
    take_status(8'h47, "R9 parity byte");
    expect_quiet("R9 byte not executed");
    send(8'h80); send(8'h11); send(8'h81); send(8'h22, 1'b1);
    take_status(8'h47, "R9 parity mid frame");
    send(8'h47); send(8'h00);
    take_status(8'h17, "R9 frame aborted");

    // R10 monitor mode
    send(8'h05);
    check(mon_mode === 1'b1, "R10 monitor on", mon_mode, 1);
    send(8'h02);
    take_status(8'h07, "R10 state in monitor");
    check(mon_mode === 1'b1, "R10 monitor sticky", mon_mode, 1);
    send(8'h01);
    check(mon_mode === 1'b0, "R10 reset clears monitor", mon_mode, 0);

    // R11 acknowledge value
    send(8'h16);
    check(ack_valid === 1'b1 && ack_flags === 3'b110, "R11 ack flags", ack_flags, 6);
    @(negedge clk);
    check(ack_valid === 1'b0, "R11 single pulse", ack_valid, 0);

    // R12 polling state
    send(8'hE9); send(8'h12); send(8'h34);
    check(poll_valid === 1'b0, "R12 not early", poll_valid, 0);
    send(8'h56);
    check(poll_valid === 1'b1 && poll_slot === 4'd9 && poll_addr === 16'h1234 && poll_state === 8'h56,
          "R12 poll fields", {poll_slot, poll_addr, poll_state}, 28'h9123456);

    // R14 external events and temperature bit
    pulse(sc_evt);
    take_status(8'h87, "R14 slave collision");
    temp_warn = 1'b1;
    send(8'h02);
    take_status(8'h0F, "R14 temperature bit");
    temp_warn = 1'b0;

    // R2 only reported flags clear
    send(8'h00);
    take_status(8'h17, "R2 first byte", 1'b0);
    pulse(te_evt);
    check(tx_byte === 8'h17, "R2 byte stable", tx_byte, 8'h17);
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    take_status(8'h27, "R2 late flag kept");
    send(8'h02);
    take_status(8'h07, "R2 flags cleared");

    // R10 reset command drops released frame
    send_frame(7, 7, 1'b1, 8'h77);
    check(frm_valid === 1'b1, "R4 release len 7", frm_valid, 1);
    send(8'h01);
    check(frm_valid === 1'b0, "R10 reset drops frame", frm_valid, 0);
    expect_quiet("R10 reset quiet");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule